// File: doc/BRIEF.md
# SGPIO LED pattern serializer

This block keeps the enclosure LED state for a group of drive ports and sends it to an external LED controller over three wires: a serial clock, a load strobe and a data line. It holds a pattern register with one three-bit group per slot. Each group carries an activity bit, a locate bit and a fault bit. A port-to-slot table, supplied as a configuration input, decides which group a port's LEDs land in.

A host logic block raises an update request carrying a port number and the LED flag bits of a state word. The block rewrites that port's group and then sends a frame with the whole pattern. A frame has four parts, in this order. First comes a configurable number of idle clocks. Next, one clock cycle is sent with load high. After that, every pattern bit is shifted out, lowest bit first. A configurable number of idle clocks closes the frame. While a frame is in flight the request port reports not-ready, so frames never overlap. The half-period of the serial clock is a parameter counted in system clock cycles.

Top module: `sgpio_led_ser`

## Requirements
- R1: After reset, the serial clock, load and data lines are all high, the block is ready, and every pattern bit is zero.
- R2: An accepted request for port p writes only the group of slot s, where s is entry p of the slot map (bits [p*PORT_W +: PORT_W]). That group is pattern bits 3*s (activity), 3*s+1 (locate) and 3*s+2 (fault). The groups of all other slots keep their values.
- R3: Activity is set when state bit 20 or state bit 21 is set. Locate equals state bit 19 and fault equals state bit 22. Each flag is cleared when its condition is false.
- R4: Each serial clock cycle stays high for HALF_CYC system cycles and then low for HALF_CYC system cycles.
- R5: A frame sends clock cycles in this order: the lead count, then one cycle with load high, then 3*NUM_PORTS data cycles, then the trail count. Load is low in every other cycle of the frame.
- R6: Data cycle i carries pattern bit i, lowest bit first. The bit is set up in the same system cycle in which the clock rises. Data and load never change while the clock is low.
- R7: The ready output falls in the cycle after a request is accepted. It stays low for exactly the frame length of (lead+1+3*NUM_PORTS+trail)*2*HALF_CYC system cycles. Requests presented while ready is low have no effect.
- R8: A request whose port number is NUM_PORTS or above is consumed without starting a frame and without changing the pattern.
- R9: The lead and trail counts are taken at the accepting edge. A count of zero adds no idle clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| upd_valid | input | 1 | Update request |
| upd_ready | output | 1 | High when a request can be accepted |
| upd_port | input | PORT_W | Port number of the request |
| upd_led | input | 4 | State word bits 22..19 (fault, activity pair, locate) |
| cfg_slot_map | input | NUM_PORTS*PORT_W | Slot number per port, entry p at [p*PORT_W +: PORT_W] |
| cfg_lead_clks | input | CNT_W | Idle clock cycles before the load cycle |
| cfg_trail_clks | input | CNT_W | Idle clock cycles after the last data bit |
| sg_clk | output | 1 | Serial clock to the LED controller |
| sg_load | output | 1 | Load strobe |
| sg_data | output | 1 | Serial data |

## Verification
The assertions assume that every slot map entry is below NUM_PORTS and that the map and count inputs stay steady from the accepting edge to the end of the frame. The bench uses only in-range permutation maps and changes configuration only while the block is idle. The clock-width property is armed only after the first observed rising edge, because the reset-high level can last for any length of time. Any request driven during a frame is withdrawn before ready returns, so the design's stall rule is the only thing that keeps it out.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_LOAD  = 3'd2,
    PH_DATA  = 3'd3,
    PH_TRAIL = 3'd4
  } sgs_phase_e;

  localparam int GRP_W   = 3;
  localparam int ACT_OFS = 0;
  localparam int LOC_OFS = 1;
  localparam int FLT_OFS = 2;

  // Input is state bits [22:19]; result is {fault, locate, activity}.
  function automatic logic [GRP_W-1:0] sgs_led_bits(input logic [3:0] st);
    logic [GRP_W-1:0] g;
    g[ACT_OFS] = st[1] | st[2];
    g[LOC_OFS] = st[0];
    g[FLT_OFS] = st[3];
    return g;
  endfunction

  // Length of a frame in serial clock cycles.
  function automatic int sgs_frame_cycles(input int lead, input int trail, input int nports);
    return lead + 1 + GRP_W * nports + trail;
  endfunction

endpackage

// File: rtl/sgs_half_timer.sv
module sgs_half_timer #(
  parameter int HALF_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_end
);
  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [TW-1:0] cnt_q;

  assign half_end = run && (cnt_q == TW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || half_end) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sgs_pattern.sv
module sgs_pattern
  import sgs_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 3,
  localparam int PAT_W    = GRP_W * NUM_PORTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [PORT_W-1:0]           wr_port,
  input  logic [3:0]                  wr_led,
  input  logic [NUM_PORTS*PORT_W-1:0] slot_map,
  output logic [PAT_W-1:0]            pat_q,
  output logic [PAT_W-1:0]            pat_nxt
);
  logic [PORT_W-1:0] wr_slot;
  logic [GRP_W-1:0]  wr_bits;
  logic [NUM_PORTS*PORT_W-1:0] map_shift;

  assign map_shift = slot_map >> (int'(wr_port) * PORT_W);
  assign wr_slot   = map_shift[PORT_W-1:0];
  assign wr_bits   = sgs_led_bits(wr_led);

  for (genvar s = 0; s < NUM_PORTS; s++) begin : g_slot
    logic hit;
    assign hit = (wr_slot == PORT_W'(s));
    assign pat_nxt[GRP_W*s +: GRP_W] = hit ? wr_bits : pat_q[GRP_W*s +: GRP_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pat_q <= '0;
    else if (wr_en) pat_q <= pat_nxt;
  end
endmodule

// File: rtl/sgs_framer.sv
module sgs_framer
  import sgs_pkg::*;
#(
  parameter int PAT_W    = 24,
  parameter int CNT_W    = 8,
  parameter int HALF_CYC = 2500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAT_W-1:0] pat_in,
  input  logic [CNT_W-1:0] lead_clks,
  input  logic [CNT_W-1:0] trail_clks,
  output logic             busy,
  output logic             sg_clk,
  output logic             sg_load,
  output logic             sg_data
);
  localparam int BIT_W = $clog2(PAT_W + 1);
  localparam int CW    = (CNT_W > BIT_W) ? CNT_W : BIT_W;

  sgs_phase_e       ph_q, ph_nxt;
  logic [CW-1:0]    cnt_q, cnt_nxt;
  logic [CNT_W-1:0] lead_q, trail_q;
  logic [PAT_W-1:0] sh_q;
  logic             hi_q, clk_q, load_q, data_q;
  logic             half_end, cyc_end;

  assign busy = (ph_q != PH_IDLE);

  sgs_half_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .half_end (half_end)
  );

  assign cyc_end = half_end && !hi_q;

  always_comb begin
    ph_nxt  = ph_q;
    cnt_nxt = cnt_q + 1'b1;
    unique case (ph_q)
      PH_LEAD:
        if (cnt_q + 1'b1 == CW'(lead_q)) begin
          ph_nxt  = PH_LOAD;
          cnt_nxt = '0;
        end
      PH_LOAD: begin
        ph_nxt  = PH_DATA;
        cnt_nxt = '0;
      end
      PH_DATA:
        if (cnt_q == CW'(PAT_W - 1)) begin
          ph_nxt  = (trail_q != '0) ? PH_TRAIL : PH_IDLE;
          cnt_nxt = '0;
        end
      PH_TRAIL:
        if (cnt_q + 1'b1 == CW'(trail_q)) begin
          ph_nxt  = PH_IDLE;
          cnt_nxt = '0;
        end
      default: begin
        ph_nxt  = PH_IDLE;
        cnt_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      lead_q  <= '0;
      trail_q <= '0;
      sh_q    <= '0;
      hi_q    <= 1'b0;
      clk_q   <= 1'b1;
      load_q  <= 1'b1;
      data_q  <= 1'b1;
    end else if (!busy) begin
      if (start) begin
        ph_q    <= (lead_clks != '0) ? PH_LEAD : PH_LOAD;
        cnt_q   <= '0;
        lead_q  <= lead_clks;
        trail_q <= trail_clks;
        sh_q    <= pat_in;
        hi_q    <= 1'b1;
        clk_q   <= 1'b1;
        load_q  <= (lead_clks == '0);
      end
    end else if (half_end && hi_q) begin
      hi_q  <= 1'b0;
      clk_q <= 1'b0;
    end else if (cyc_end) begin
      ph_q  <= ph_nxt;
      cnt_q <= cnt_nxt;
      if (ph_nxt == PH_IDLE) begin
        load_q <= 1'b0;
      end else begin
        hi_q   <= 1'b1;
        clk_q  <= 1'b1;
        load_q <= (ph_nxt == PH_LOAD);
        if (ph_nxt == PH_DATA) begin
          data_q <= sh_q[0];
          sh_q   <= sh_q >> 1;
        end
      end
    end
  end

  assign sg_clk  = clk_q;
  assign sg_load = load_q;
  assign sg_data = data_q;
endmodule

// File: rtl/sgpio_led_ser.sv
module sgpio_led_ser
  import sgs_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int CNT_W     = 8,
  parameter int HALF_CYC  = 2500,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int PAT_W    = GRP_W * NUM_PORTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd_valid,
  output logic                        upd_ready,
  input  logic [PORT_W-1:0]           upd_port,
  input  logic [22:19]                upd_led,
  input  logic [NUM_PORTS*PORT_W-1:0] cfg_slot_map,
  input  logic [CNT_W-1:0]            cfg_lead_clks,
  input  logic [CNT_W-1:0]            cfg_trail_clks,
  output logic                        sg_clk,
  output logic                        sg_load,
  output logic                        sg_data
);
  logic             frame_busy;
  logic             accept;
  logic             port_ok;
  logic             wr_en;
  logic [PAT_W-1:0] pat_q, pat_nxt;

  assign upd_ready = !frame_busy;
  assign accept    = upd_valid && upd_ready;
  assign port_ok   = ({1'b0, upd_port} < (PORT_W + 1)'(NUM_PORTS));
  assign wr_en     = accept && port_ok;

  sgs_pattern #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
  ) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_port  (upd_port),
    .wr_led   (upd_led),
    .slot_map (cfg_slot_map),
    .pat_q    (pat_q),
    .pat_nxt  (pat_nxt)
  );

  sgs_framer #(
    .PAT_W    (PAT_W),
    .CNT_W    (CNT_W),
    .HALF_CYC (HALF_CYC)
  ) u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (wr_en),
    .pat_in     (pat_nxt),
    .lead_clks  (cfg_lead_clks),
    .trail_clks (cfg_trail_clks),
    .busy       (frame_busy),
    .sg_clk     (sg_clk),
    .sg_load    (sg_load),
    .sg_data    (sg_data)
  );
endmodule

// File: rtl/sgpio_led_ser_chk.sv
module sgpio_led_ser_chk #(
  parameter int HALF_CYC = 2500
) (
  input logic clk,
  input logic rst_n,
  input logic upd_valid,
  input logic upd_ready,
  input logic port_ok,
  input logic sg_clk,
  input logic sg_load,
  input logic sg_data
);
  logic        prev_q;
  logic        seen_rise_q;
  logic [15:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= 1'b1;
      seen_rise_q <= 1'b0;
      run_q       <= '0;
    end else begin
      prev_q <= sg_clk;
      if (sg_clk != prev_q) begin
        run_q <= 16'd1;
        if (sg_clk) seen_rise_q <= 1'b1;
      end else if (run_q != 16'hFFFF) begin
        run_q <= run_q + 16'd1;
      end
    end
  end

  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && port_ok) |=> !upd_ready); // R7

  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sg_clk) && seen_rise_q) |-> (run_q == 16'(HALF_CYC))); // R4

  AST_QUIET_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sg_clk |-> ($stable(sg_data) && $stable(sg_load))); // R6

  AST_FRAME_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_ready) |-> !sg_clk); // R5

  AST_LOAD_DROPS_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sg_load) |-> sg_clk); // R5
endmodule

bind sgpio_led_ser sgpio_led_ser_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_valid (upd_valid),
  .upd_ready (upd_ready),
  .port_ok   (port_ok),
  .sg_clk    (sg_clk),
  .sg_load   (sg_load),
  .sg_data   (sg_data)
);

// File: tb/sgpio_led_ser_bench.sv
module sgpio_led_ser_bench;
  localparam int NP  = 3;
  localparam int PW  = 2;
  localparam int CW  = 4;
  localparam int HC  = 2;
  localparam int NB  = 3 * NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd_valid = 1'b0;
  logic          upd_ready;
  logic [PW-1:0] upd_port = '0;
  logic [22:19]  upd_led = '0;
  logic [NP*PW-1:0] cfg_slot_map = {2'd2, 2'd1, 2'd0};
  logic [CW-1:0] cfg_lead_clks = '0;
  logic [CW-1:0] cfg_trail_clks = '0;
  logic          sg_clk, sg_load, sg_data;

  int total = 0;
  int bad = 0;
  logic [NB-1:0] exp_pat = '0;

  always #10 clk = ~clk;

  sgpio_led_ser #(.NUM_PORTS(NP), .CNT_W(CW), .HALF_CYC(HC)) u_sgpio_led_ser (
    .clk, .rst_n, .upd_valid, .upd_ready, .upd_port, .upd_led,
    .cfg_slot_map, .cfg_lead_clks, .cfg_trail_clks,
    .sg_clk, .sg_load, .sg_data
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int port, input logic [31:0] st, input int lead,
                      input int trail, input bit poke, input string dtag);
    int nsamp = 0;
    int ncyc = 0;
    int run = 0;
    int bad_t = 0;
    int exp_cyc;
    int slot;
    int ld_err = 0;
    int dt_err = 0;
    bit poke_ok = 1'b1;
    logic prev = 1'b0;
    logic ld [64];
    logic dt [64];
    while (!upd_ready) @(negedge clk);
    upd_port = PW'(port);
    upd_led = st[22:19];
    cfg_lead_clks = CW'(lead);
    cfg_trail_clks = CW'(trail);
    upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    slot = int'((cfg_slot_map >> (port * PW)) & 2'b11);
    exp_pat[3*slot]     = st[20] | st[21];
    exp_pat[3*slot + 1] = st[19];
    exp_pat[3*slot + 2] = st[22];
    exp_cyc = lead + 1 + NB + trail;
    while (!upd_ready && nsamp < 5000) begin
      if (sg_clk && (nsamp == 0 || !prev)) begin
        if (nsamp != 0 && run != HC) bad_t++;
        if (ncyc < 64) begin
          ld[ncyc] = sg_load;
          dt[ncyc] = sg_data;
        end
        ncyc++;
        run = 1;
      end else if (sg_clk != prev) begin
        if (run != HC) bad_t++;
        run = 1;
      end else begin
        run++;
      end
      if (poke && nsamp == 5) begin
        upd_valid = 1'b1;
        upd_port = '0;
        upd_led = 4'hF;
      end
      if (poke && nsamp == 7) begin
        poke_ok = !upd_ready;
        upd_valid = 1'b0;
      end
      prev = sg_clk;
      nsamp++;
      @(negedge clk);
    end
    if (run != HC) bad_t++;
    chk(ncyc == exp_cyc, "R5 R9 clock cycles per frame", ncyc, exp_cyc);
    chk(bad_t == 0, "R4 half-period widths", bad_t, 0);
    chk(nsamp == exp_cyc * 2 * HC, "R7 ready low for frame length", nsamp, exp_cyc * 2 * HC);
    if (poke) chk(poke_ok, "R7 ready low mid-frame", 1, 0);
    if (ncyc == exp_cyc) begin
      for (int i = 0; i < ncyc; i++)
        if (ld[i] !== (i == lead)) ld_err++;
      for (int i = 0; i < NB; i++)
        if (dt[lead + 1 + i] !== exp_pat[i]) dt_err++;
    end else begin
      ld_err = -1;
      dt_err = -1;
    end
    chk(ld_err == 0, "R5 load in one cycle only", ld_err, 0);
    chk(dt_err == 0, dtag, dt_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] st;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sg_clk === 1'b1, "R1 clock high after reset", int'(sg_clk), 1);
    chk(sg_load === 1'b1, "R1 load high after reset", int'(sg_load), 1);
    chk(sg_data === 1'b1, "R1 data high after reset", int'(sg_data), 1);
    chk(upd_ready === 1'b1, "R1 ready after reset", int'(upd_ready), 1);
    // first frame: only slot 0 written, the other groups must show zero
    send(0, 32'h0000_0000, 0, 0, 1'b0, "R1 pattern zero after reset");

    for (int m = 0; m < 2; m++) begin
      cfg_slot_map = (m == 0) ? {2'd2, 2'd1, 2'd0} : {2'd1, 2'd0, 2'd2};
      for (int p = 0; p < NP; p++) begin
        for (int k = 0; k < 8; k++) begin
          st = (32'hA5A5_A5A5 ^ (32'(k) * 32'h0101_0101)) & ~32'h0078_0000;
          if (k[0]) st |= (p % 2 == 0) ? 32'h0010_0000 : 32'h0020_0000;
          if (k[1]) st |= 32'h0008_0000;
          if (k[2]) st |= 32'h0040_0000;
          send(p, st, k % 3, (k + p) % 3, (k == 5), "R2 R3 R6 data bits LSB first");
        end
      end
    end

    // both activity sources together
    send(1, 32'h0030_0000, 2, 1, 1'b0, "R3 activity from both bits");

    // out-of-range port
    while (!upd_ready) @(negedge clk);
    upd_port = 2'd3;
    upd_led = 4'hF;
    upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    begin
      int quiet_err = 0;
      for (int i = 0; i < 12; i++) begin
        if (sg_clk !== 1'b0 || upd_ready !== 1'b1) quiet_err++;
        @(negedge clk);
      end
      chk(quiet_err == 0, "R8 no frame for bad port", quiet_err, 0);
    end
    send(2, 32'h0000_0000, 1, 2, 1'b0, "R8 pattern unchanged by bad port");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule